// File: doc/BRIEF.md
# Flash Program/Erase Completion Poller

This block runs on the host side of a byte-wide flash device. A program-byte or erase-sector command has already been sent. The block then reads one flash location again and again until the device reports, through the status bits of the returned byte, that its internal algorithm has finished. When a program finishes, the block makes one more read of the location and compares the whole byte with the intended value. It then reports one result: success, timeout/device error, or verify mismatch.

Status bit 7 is the completion flag.
- For a program, the operation is complete when bit 7 equals bit 7 of the intended data.
- For an erase, the operation is complete when bit 7 reads 1.

Status bit 5 is the device error bit. Bit 7 can change in the same read that sets bit 5. So when bit 5 is seen without completion, the block reads once more before it decides the operation failed. A host-side limit on poll reads stops the wait if the device never answers with completion.

Top module: `flash_poll_checker`

## Requirements
- R1: After reset, `busy_o`, `rd_req_o`, `done_o`, `pass_o`, `timeout_o` and `verify_err_o` are all 0.
- R2: A `start_i` pulse while idle latches `op_erase_i`, `addr_i` and `data_i`. From the next cycle, `busy_o` and `rd_req_o` are 1 and `rd_addr_o` equals the latched address. A request is held, with a stable address, until a cycle in which `rd_valid_i` is 1.
- R3: For a program (`op_erase_i`=0), a poll read whose bit 7 equals bit 7 of the latched data completes the program, whatever bit 5 reads.
- R4: A poll read with bit 5 = 1 and no completion causes exactly one more read. If that read's bit 7 shows completion, the operation continues as a success. Otherwise the operation ends with `timeout_o`.
- R5: For an erase (`op_erase_i`=1), a poll read with bit 7 = 1 ends the operation with `pass_o`, and no verify read follows.
- R6: After a program completes, exactly one verify read is made. If all 8 bits equal the latched data, the result is `pass_o`. Otherwise the result is `verify_err_o`, and `pass_o` stays 0.
- R7: If MAX_POLLS poll reads in a row show neither completion nor bit 5, the operation ends with `timeout_o`. A completion on the MAX_POLLS-th poll read still succeeds. The re-check read and the verify read do not count as poll reads.
- R8: `done_o` is a one-cycle pulse. It rises in the cycle after the final read is accepted, together with exactly one of `pass_o`, `timeout_o` or `verify_err_o`. That result flag holds until the next accepted start, and an accepted start clears it.
- R9: A `start_i` pulse while `busy_o` is 1 is ignored. The address, operation and data of the operation in flight are unchanged.
- R10: A poll read with bit 5 = 0 and no completion, below the limit, is followed by another poll read at the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin polling (one-cycle pulse) |
| op_erase_i | input | 1 | 1 = erase sector, 0 = program byte |
| addr_i | input | AW | Location to poll |
| data_i | input | 8 | Intended program data |
| rd_req_o | output | 1 | Read request, held until accepted |
| rd_addr_o | output | AW | Read address |
| rd_valid_i | input | 1 | Read data valid; accepts the request |
| rd_data_i | input | 8 | Read data |
| busy_o | output | 1 | Operation in flight |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Operation succeeded |
| timeout_o | output | 1 | Device error or poll limit reached |
| verify_err_o | output | 1 | Verify readback mismatch |

## Verification
The hardest case to reach is the one where bit 5 is set and the error looks final, but bit 7 changes on the very next read. There are two outcomes for the bench to separate: a pass, and a real failure, each for both a program and an erase. The bench device model answers each accepted request with the next byte of a scripted list, and it varies the response latency. Scripts that place a bit-5 byte right before a completing or non-completing byte drive both branches. Scripts with exactly MAX_POLLS-1 and exactly MAX_POLLS busy bytes bracket the poll limit.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_POLL,
    ST_RECHECK,
    ST_VERIFY
  } fp_state_e;

  typedef enum logic [1:0] {
    RES_NONE,
    RES_PASS,
    RES_TIMEOUT,
    RES_VERIFY
  } fp_result_e;

  localparam int unsigned DW       = 8;
  localparam int unsigned FLAG_BIT = 7;
  localparam int unsigned ERR_BIT  = 5;
endpackage

// File: rtl/flash_poll_eval.sv
module flash_poll_eval
  import flash_poll_pkg::*;
(
  input  logic          is_erase_i,
  input  logic [DW-1:0] want_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          flag_match_o,
  output logic          err_set_o,
  output logic          byte_match_o
);
  logic target;

  // erase completes on an all-ones flag; program on the intended bit
  assign target       = is_erase_i ? 1'b1 : want_i[FLAG_BIT];
  assign flag_match_o = (rd_data_i[FLAG_BIT] == target);
  assign err_set_o    = rd_data_i[ERR_BIT];
  assign byte_match_o = (rd_data_i == want_i);
endmodule

// File: rtl/flash_poll_limit.sv
module flash_poll_limit #(
  parameter int unsigned MAX_POLLS = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned CW = $clog2(MAX_POLLS + 1);
  localparam logic [CW-1:0] LAST = CW'(MAX_POLLS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  // high while the read being accepted is the final allowed poll
  assign last_o = (cnt_q == LAST);
endmodule

// File: rtl/flash_poll_checker.sv
module flash_poll_checker
  import flash_poll_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned MAX_POLLS = 4096
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          op_erase_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_valid_i,
  input  logic [7:0]    rd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          pass_o,
  output logic          timeout_o,
  output logic          verify_err_o
);
  fp_state_e     state_q;
  fp_result_e    res_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          erase_q;
  logic          done_q;

  logic flag_match, err_set, byte_match, last_poll;
  logic accept, poll_hit;

  assign accept   = (state_q == ST_IDLE) && start_i;
  assign poll_hit = (state_q == ST_POLL) && rd_valid_i;

  flash_poll_eval u_eval (
    .is_erase_i  (erase_q),
    .want_i      (data_q),
    .rd_data_i   (rd_data_i),
    .flag_match_o(flag_match),
    .err_set_o   (err_set),
    .byte_match_o(byte_match)
  );

  flash_poll_limit #(.MAX_POLLS(MAX_POLLS)) u_limit (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(accept),
    .inc_i  (poll_hit),
    .last_o (last_poll)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      res_q   <= RES_NONE;
      addr_q  <= '0;
      data_q  <= '0;
      erase_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            addr_q  <= addr_i;
            data_q  <= data_i;
            erase_q <= op_erase_i;
            res_q   <= RES_NONE;
            state_q <= ST_POLL;
          end
        end
        ST_POLL: begin
          if (rd_valid_i) begin
            if (flag_match) begin
              if (erase_q) begin
                res_q   <= RES_PASS;
                done_q  <= 1'b1;
                state_q <= ST_IDLE;
              end else begin
                state_q <= ST_VERIFY;
              end
            end else if (err_set) begin
              state_q <= ST_RECHECK;
            end else if (last_poll) begin
              res_q   <= RES_TIMEOUT;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        ST_RECHECK: begin
          if (rd_valid_i) begin
            if (flag_match && !erase_q) begin
              state_q <= ST_VERIFY;
            end else begin
              res_q   <= flag_match ? RES_PASS : RES_TIMEOUT;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        ST_VERIFY: begin
          if (rd_valid_i) begin
            res_q   <= byte_match ? RES_PASS : RES_VERIFY;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign rd_req_o     = busy_o;
  assign rd_addr_o    = addr_q;
  assign done_o       = done_q;
  assign pass_o       = (res_q == RES_PASS);
  assign timeout_o    = (res_q == RES_TIMEOUT);
  assign verify_err_o = (res_q == RES_VERIFY);
endmodule

// File: rtl/flash_poll_sva.sv
module flash_poll_sva #(
  parameter int unsigned AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          rd_req_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          rd_valid_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          pass_o,
  input logic          timeout_o,
  input logic          verify_err_o
);
  a_r1_idle_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> busy_o);

  a_r2_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_valid_i) |=> (rd_req_o && $stable(rd_addr_o)));

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_one_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($countones({pass_o, timeout_o, verify_err_o}) == 1));

  a_r6_pass_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pass_o, timeout_o, verify_err_o}));

  a_r9_busy_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && $past(busy_o)) |=> (busy_o ? $stable(rd_addr_o) : 1'b1));
endmodule

bind flash_poll_checker flash_poll_sva #(.AW(AW)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .rd_req_o    (rd_req_o),
  .rd_addr_o   (rd_addr_o),
  .rd_valid_i  (rd_valid_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .pass_o      (pass_o),
  .timeout_o   (timeout_o),
  .verify_err_o(verify_err_o)
);

// File: tb/flash_poll_checker_tb.sv
module flash_poll_checker_tb;
  localparam int AW = 12;
  localparam int MAXP = 8;
  localparam int R_PASS = 1, R_TMO = 2, R_VER = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic          op_erase_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0]    data_i = '0;
  logic          rd_req_o;
  logic [AW-1:0] rd_addr_o;
  logic          rd_valid_i = 1'b0;
  logic [7:0]    rd_data_i = '0;
  logic          busy_o, done_o, pass_o, timeout_o, verify_err_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0]    script[$];
  logic [7:0]    fill = 8'h00;
  int            dev_idx = 0;
  int            lat = 0;
  int            lat_cnt = 0;
  logic [AW-1:0] cur_addr = '0;
  bit            track = 1'b0;

  always #5 clk_i = ~clk_i;

  flash_poll_checker #(.AW(AW), .MAX_POLLS(MAXP)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // device model plus per-clock address comparison
  always @(negedge clk_i) begin
    if (track && rd_req_o)
      chk(rd_addr_o == cur_addr, "R2", "read address", int'(rd_addr_o), int'(cur_addr));
    if (rd_valid_i) begin
      rd_valid_i = 1'b0;
      lat_cnt = 0;
    end else if (rd_req_o) begin
      if (lat_cnt >= lat) begin
        rd_data_i  = (dev_idx < script.size()) ? script[dev_idx] : fill;
        rd_valid_i = 1'b1;
        dev_idx++;
      end else begin
        lat_cnt++;
      end
    end
  end

  function automatic logic [7:0] pick(int i);
    return (i < script.size()) ? script[i] : fill;
  endfunction

  // reference model: outcome and read count from the requirements
  task automatic predict(input bit er, input logic [7:0] d, output int res, output int reads);
    int polls = 0;
    logic [7:0] b;
    bit tgt = er ? 1'b1 : d[7];
    bit ok = 1'b0;
    reads = 0;
    res = 0;
    while (res == 0 && !ok) begin
      b = pick(reads); reads++; polls++;
      if (b[7] == tgt) ok = 1'b1;
      else if (b[5]) begin
        b = pick(reads); reads++;
        if (b[7] == tgt) ok = 1'b1; else res = R_TMO;
      end else if (polls == MAXP) res = R_TMO;
    end
    if (ok) begin
      if (er) res = R_PASS;
      else begin
        b = pick(reads); reads++;
        res = (b == d) ? R_PASS : R_VER;
      end
    end
  endtask

  task automatic run_op(input bit er, input logic [AW-1:0] a, input logic [7:0] d,
                        input int l, input string req, input bit poke);
    int exp_res, exp_reads, cyc, got;
    predict(er, d, exp_res, exp_reads);
    dev_idx = 0; lat = l; lat_cnt = 0; cur_addr = a;
    @(negedge clk_i);
    start_i = 1'b1; op_erase_i = er; addr_i = a; data_i = d;
    @(negedge clk_i);
    start_i = 1'b0; track = 1'b1;
    chk(busy_o && rd_req_o, "R2", "busy/req after start", {busy_o, rd_req_o}, 3);
    chk({pass_o, timeout_o, verify_err_o} == 3'b000, "R8", "flags cleared on start",
        {pass_o, timeout_o, verify_err_o}, 0);
    if (poke) begin
      start_i = 1'b1; op_erase_i = ~er; addr_i = ~a; data_i = ~d;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    cyc = 0;
    while (!done_o && cyc < 2000) begin
      @(negedge clk_i);
      cyc++;
    end
    chk(done_o, req, "done seen", done_o, 1);
    got = pass_o ? R_PASS : timeout_o ? R_TMO : verify_err_o ? R_VER : 0;
    chk(got == exp_res, req, "result code", got, exp_res);
    chk(dev_idx == exp_reads, req, "read count", dev_idx, exp_reads);
    @(negedge clk_i);
    track = 1'b0;
    chk(!done_o && !busy_o, "R8", "done one cycle, idle", {done_o, busy_o}, 0);
    got = pass_o ? R_PASS : timeout_o ? R_TMO : verify_err_o ? R_VER : 0;
    chk(got == exp_res, "R8", "result held", got, exp_res);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk({busy_o, rd_req_o, done_o, pass_o, timeout_o, verify_err_o} == 6'b0, "R1",
        "reset outputs", {busy_o, rd_req_o, done_o, pass_o, timeout_o, verify_err_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !rd_req_o, "R1", "idle after reset", {busy_o, rd_req_o}, 0);

    // R10 + R3: busy polls then match, program bit7=1
    script = '{8'h05, 8'h05, 8'hA5, 8'hA5}; fill = 8'h00;
    run_op(1'b0, 12'h123, 8'hA5, 0, "R10", 1'b0);
    // R3: program bit7=0
    script = '{8'h80, 8'h3C, 8'h3C};
    run_op(1'b0, 12'h456, 8'h3C, 1, "R3", 1'b0);
    // R3: match wins even with bit5 set
    script = '{8'hA0, 8'hA0};
    run_op(1'b0, 12'h010, 8'hA0, 0, "R3", 1'b0);
    // R6: verify mismatch
    script = '{8'hA5, 8'hA4};
    run_op(1'b0, 12'h7FF, 8'hA5, 2, "R6", 1'b0);
    // R4: error bit then recheck completes
    script = '{8'h20, 8'h81, 8'h81};
    run_op(1'b0, 12'h200, 8'h81, 1, "R4", 1'b0);
    // R4: error bit then recheck fails
    script = '{8'h20, 8'h20, 8'h81};
    run_op(1'b0, 12'h201, 8'h81, 0, "R4", 1'b0);
    // R5: erase success, no verify read
    script = '{8'h00, 8'h00, 8'hFF, 8'h00};
    run_op(1'b1, 12'hABC, 8'h00, 1, "R5", 1'b0);
    // R4 on erase: error then fail / then pass
    script = '{8'h20, 8'h20};
    run_op(1'b1, 12'h300, 8'h00, 0, "R4", 1'b0);
    script = '{8'h00, 8'h20, 8'h80};
    run_op(1'b1, 12'h301, 8'h00, 2, "R4", 1'b0);
    // R7: limit reached
    script = '{}; fill = 8'h00;
    run_op(1'b0, 12'h0F0, 8'h80, 0, "R7", 1'b0);
    // R7: completion on the last allowed poll
    script = '{};
    for (int i = 0; i < MAXP - 1; i++) script.push_back(8'h00);
    script.push_back(8'h80); script.push_back(8'h80);
    run_op(1'b0, 12'h0F1, 8'h80, 1, "R7", 1'b0);
    // R9: start while busy ignored
    script = '{8'h00, 8'h00, 8'h00, 8'h5A, 8'h5A};
    run_op(1'b0, 12'h555, 8'h5A, 2, "R9", 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule